// File: doc/BRIEF.md
# System control register file

This block is a bank of 32-bit control and identification words behind a simple slave bus. The bus is one word wide, has single-cycle accesses and a 4 KiB byte window. The low half of the window holds 512 general-purpose words that software can write and read back. At reset, four of those words load fixed identification values and every other word loads zero. When software reads three of the identification words, two status bits always come back set, whatever is stored there.

The upper half of the window has no storage. A write or read there is reported as a bad access on a one-cycle error flag. A read there returns zero. One offset in that upper half is a command port. Writing a command code to it sends a one-cycle request to the chip's reset or power logic: codes 1 and 2 request a system reset, code 3 requests a shutdown, and any other code does nothing. Each request pulse rises on the clock edge that accepts the write.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, word index 0x40 reads 0x05F20121 with bits 29:28 forced, word 0x41 reads 0x00000002, word 0x42 reads 0x05F30121 with bits 29:28 forced, word 0x43 reads 0x05F40121 with bits 29:28 forced, and every other word reads zero. All outputs are low while reset is held.
- R2: A write to word index `addr[11:2]` below 512 stores the data. A read strobe at edge N drives `bus_rvalid` high for exactly one cycle after edge N, with `bus_rdata` holding the stored word.
- R3: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000, and the stored value itself is not changed. No other offset has bits forced.
- R4: A write at byte offset 0x800 or above leaves all storage unchanged and pulses `bus_err` for one cycle after the write edge.
- R5: A read at byte offset 0x800 or above returns zero with `bus_rvalid` high, and pulses `bus_err` in the same cycle.
- R6: A write of data 1 or 2 to byte offset 0xF00 pulses `sys_reset_req` for one cycle after the write edge.
- R7: A write of data 3 to byte offset 0xF00 pulses `sys_shutdown_req` for one cycle. Any other data value written there raises no request. A write of 1, 2 or 3 to any other offset raises no request.
- R8: Address bits 1:0 are ignored on every access, including the command port.
- R9: `sys_reset_req` and `sys_shutdown_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; zero when no read is being returned |
| bus_rvalid | output | 1 | Read data is valid this cycle |
| bus_err | output | 1 | Bad access: offset lies past the storage |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_shutdown_req | output | 1 | One-cycle system shutdown request |

## Verification
Every result of this block is due exactly one cycle after its strobe: the read word and its valid flag, the error flag, and both request pulses. In every cycle, the driver queues the full output vector that the cycle must produce, even when that cycle is idle. The monitor takes one entry per clock, shortly after the edge that registers the strobe. A stray pulse or a late pulse therefore shows up as a mismatch in a neighbouring cycle. It cannot slip by unchecked.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned SC_DATA_W = 32;
  localparam logic [SC_DATA_W-1:0] SC_STATUS_MASK = 32'h3000_0000;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'd0,
    CMD_RESET    = 2'd1,
    CMD_SHUTDOWN = 2'd2
  } sc_cmd_e;

  // value a word takes at reset
  function automatic logic [SC_DATA_W-1:0] word_reset_value(input int unsigned idx);
    case (idx)
      32'h40:  return 32'h05F2_0121;
      32'h41:  return 32'h0000_0002;
      32'h42:  return 32'h05F3_0121;
      32'h43:  return 32'h05F4_0121;
      default: return '0;
    endcase
  endfunction

  // words whose reads carry the forced status bits
  function automatic logic word_forces_status(input int unsigned idx);
    return (idx == 32'h40) || (idx == 32'h42) || (idx == 32'h43);
  endfunction

  // command code to request kind; reset wins if codes ever overlap
  function automatic sc_cmd_e decode_cmd(input logic [SC_DATA_W-1:0] d);
    if (d == 32'd1 || d == 32'd2) return CMD_RESET;
    if (d == 32'd3)               return CMD_SHUTDOWN;
    return CMD_NONE;
  endfunction

endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned NUM_WORDS  = 512,
  parameter int unsigned CMD_OFFSET = 32'hF00,
  localparam int unsigned FULL_W    = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [FULL_W-1:0] word_idx,
  output logic              in_range,
  output logic              is_cmd
);
  localparam logic [FULL_W-1:0] CMD_IDX = FULL_W'(CMD_OFFSET >> 2);

  assign word_idx = addr[ADDR_W-1:2];
  assign in_range = ({1'b0, word_idx} < (FULL_W + 1)'(NUM_WORDS));
  assign is_cmd   = (word_idx == CMD_IDX);
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 512,
  parameter int unsigned DATA_W    = SC_DATA_W,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rword
);
  logic [DATA_W-1:0] mem [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NUM_WORDS); i++) begin
        mem[i] <= DATA_W'(word_reset_value(i));
      end
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rword = mem[ridx];
endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = SC_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              reset_req,
  output logic              shutdown_req
);
  sc_cmd_e cmd_kind;
  assign cmd_kind = cmd_wr ? decode_cmd(SC_DATA_W'(wdata)) : CMD_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_req    <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      reset_req    <= (cmd_kind == CMD_RESET);
      shutdown_req <= (cmd_kind == CMD_SHUTDOWN);
    end
  end

  // R9
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reset_req && shutdown_req));

  // R6
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (wdata == DATA_W'(1) || wdata == DATA_W'(2))) |=> reset_req);

  // R7
  shutdown_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata == DATA_W'(3)) |=> shutdown_req);

  // R7
  no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (!reset_req && !shutdown_req));
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned NUM_WORDS  = 512,
  parameter int unsigned CMD_OFFSET = 32'hF00,
  localparam int unsigned DATA_W    = SC_DATA_W,
  localparam int unsigned FULL_W    = ADDR_W - 2,
  localparam int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  output logic              sys_reset_req,
  output logic              sys_shutdown_req
);
  logic [FULL_W-1:0] word_idx;
  logic              in_range;
  logic              is_cmd;
  logic [DATA_W-1:0] stored_word;
  logic              force_status;
  logic              store_we;
  logic              cmd_wr;
  logic              bad_access;

  sysctl_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .CMD_OFFSET(CMD_OFFSET)
  ) u_dec (
    .addr(bus_addr), .word_idx(word_idx), .in_range(in_range), .is_cmd(is_cmd)
  );

  assign store_we     = bus_wr && in_range;
  assign cmd_wr       = bus_wr && is_cmd;
  assign bad_access   = (bus_wr || bus_rd) && !in_range;
  assign force_status = word_forces_status(int'(word_idx));

  sysctl_store #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(store_we),
    .widx(word_idx[IDX_W-1:0]), .wdata(bus_wdata),
    .ridx(word_idx[IDX_W-1:0]), .rword(stored_word)
  );

  sysctl_cmd #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(bus_wdata),
    .reset_req(sys_reset_req), .shutdown_req(sys_shutdown_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_err    <= bad_access;
      if (bus_rd && in_range)
        bus_rdata <= stored_word | (force_status ? SC_STATUS_MASK : '0);
      else
        bus_rdata <= '0;
    end
  end

  // R2
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd));

  // R3
  status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && in_range && force_status) |=> (bus_rdata[29:28] == 2'b11));

  // R4
  bad_wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !in_range) |=> bus_err);

  // R5
  bad_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !in_range) |=> (bus_err && bus_rvalid && bus_rdata == '0));
endmodule

// File: tb/sysctl_regfile_bench.sv
module sysctl_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err, sys_reset_req, sys_shutdown_req;

  always #5 clk = ~clk;

  sysctl_regfile u_sysctl_regfile (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err),
    .sys_reset_req(sys_reset_req), .sys_shutdown_req(sys_shutdown_req)
  );

  typedef struct {
    logic [35:0] vec; // {rvalid, rdata, err, reset_req, shutdown_req}
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [31:0] model [512];
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;

  function automatic logic [35:0] out_vec();
    return {bus_rvalid, bus_rdata, bus_err, sys_reset_req, sys_shutdown_req};
  endfunction

  // monitor: one expected entry per clock, sampled after the edge
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (out_vec() !== e.vec) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", e.tag, out_vec(), e.vec);
      end
    end
  end

  // driver: applies one access and queues what the next cycle must show
  task automatic op(input logic wr, input logic rd, input logic [11:0] a,
                    input logic [31:0] d, input string tag);
    int unsigned idx;
    logic        bad;
    logic [31:0] rexp;
    logic        rq, sq;
    exp_t        e;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    idx  = int'(a >> 2);
    bad  = (idx >= 512);
    rexp = 32'h0;
    if (rd && !bad) begin
      rexp = model[idx];
      if (idx == 32'h40 || idx == 32'h42 || idx == 32'h43) rexp = rexp | 32'h3000_0000;
    end
    rq = wr && (idx == 32'h3C0) && (d == 32'd1 || d == 32'd2);
    sq = wr && (idx == 32'h3C0) && (d == 32'd3);
    e.vec = {rd, rexp, (wr || rd) && bad, rq, sq};
    e.tag = tag;
    q.push_back(e);
    if (wr && !bad) model[idx] = d;
  endtask

  task automatic wr_op(input logic [11:0] a, input logic [31:0] d, input string tag);
    op(1'b1, 1'b0, a, d, tag);
  endtask

  task automatic rd_op(input logic [11:0] a, input string tag);
    op(1'b0, 1'b1, a, 32'h0, tag);
  endtask

  task automatic idle(input string tag);
    op(1'b0, 1'b0, 12'h0, 32'h0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 32'h0;
    model[32'h40] = 32'h05F2_0121;
    model[32'h41] = 32'h0000_0002;
    model[32'h42] = 32'h05F3_0121;
    model[32'h43] = 32'h05F4_0121;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_vec() !== 36'h0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%h expected=%h", out_vec(), 36'h0);
    end
    rst_n = 1'b1;

    // R1 reset contents
    rd_op(12'h100, "R1 word40");
    rd_op(12'h104, "R1 word41");
    rd_op(12'h108, "R1 word42");
    rd_op(12'h10C, "R1 word43");
    rd_op(12'h000, "R1 word0");
    rd_op(12'h7FC, "R1 last word");
    // R2 write and read back, several patterns
    wr_op(12'h004, 32'hDEAD_BEEF, "R2 wr");
    wr_op(12'h7FC, 32'hA5A5_5A5A, "R2 wr last");
    idle("R2 idle");
    rd_op(12'h004, "R2 rd");
    rd_op(12'h7FC, "R2 rd last");
    wr_op(12'h200, 32'hFFFF_FFFF, "R2 wr ones");
    rd_op(12'h200, "R2 rd ones");
    // R3 forced bits, stored value kept
    wr_op(12'h100, 32'h0000_0000, "R3 wr40");
    rd_op(12'h100, "R3 rd40");
    wr_op(12'h104, 32'h0000_0000, "R3 wr41");
    rd_op(12'h104, "R3 rd41 no force");
    wr_op(12'h10C, 32'h3000_0001, "R3 wr43");
    rd_op(12'h10C, "R3 rd43");
    rd_op(12'h110, "R3 rd44 no force");
    // R4 bad writes leave storage untouched
    wr_op(12'h804, 32'h1234_5678, "R4 bad wr");
    wr_op(12'hFFC, 32'h1111_1111, "R4 bad wr top");
    rd_op(12'h004, "R4 storage intact");
    rd_op(12'h000, "R4 word0 intact");
    // R5 bad reads
    rd_op(12'h800, "R5 bad rd");
    rd_op(12'hF00, "R5 bad rd cmd");
    // R6 / R7 command port
    wr_op(12'hF00, 32'd1, "R6 code1");
    idle("R6 pulse ends");
    wr_op(12'hF00, 32'd2, "R6 code2");
    wr_op(12'hF00, 32'd3, "R7 code3");
    wr_op(12'hF00, 32'd0, "R7 code0");
    wr_op(12'hF00, 32'd4, "R7 code4");
    wr_op(12'h00C, 32'd1, "R7 code1 elsewhere");
    wr_op(12'hF04, 32'd3, "R7 code3 next word");
    // R8 low address bits ignored
    wr_op(12'h013, 32'hCAFE_F00D, "R8 wr");
    rd_op(12'h010, "R8 rd");
    rd_op(12'h101, "R8 rd forced");
    wr_op(12'hF02, 32'd3, "R8 cmd shutdown");
    wr_op(12'hF03, 32'd2, "R8 cmd reset");
    // R9 back to back commands never overlap
    wr_op(12'hF00, 32'd3, "R9 shut");
    wr_op(12'hF00, 32'd1, "R9 reset");
    idle("R9 quiet");
    repeat (3) @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule